// File: doc/BRIEF.md
# E1 Framer Host Register Port

This block connects an 8-bit host processor bus to the register space of an E1 framer. Two static straps set how it reads the host pins. One strap chooses a split bus or a shared bus. On the split bus the address comes in on its own pins and the data pins carry only data. On the shared bus the data pins carry the address first, then the data. The other strap chooses the strobe style: separate read and write strobes, or a single data strobe plus a direction line. All host pins are sampled in the block's own clock domain. The block turns each host cycle into a register address, a single-cycle write enable with its data, and a read enable.

The block answers some addresses itself. A fixed identification byte sits at 0Fh. Reserved locations read as zero. The upper four 16-byte banks are not accessible. No write to any of these places is passed on. All other addresses, including the two test registers at 15h and 19h, go to the register file outside the block. Software must clear those two test registers at start-up. Read data comes back on `ad_out`, and `ad_oe` is high while the host is reading.

Top module: `e1_host_port`

## Requirements
- R1: While `cs_n` is high, no strobe has any effect: `reg_wr_en` stays low and `ad_oe` stays low.
- R2: With `mux_sel` low, the access address is `{ale_a7, addr_lo[6:0]}`, so `ale_a7` acts as address bit 7.
- R3: With `mux_sel` high, the address is the value on `ad_in` at the rising edge of `ale_a7`. In this mode `addr_lo` is ignored.
- R4: With `bus_type` low, `rd_ds_n` is an active-low read strobe and `wr_rw_n` is an active-low write strobe.
- R5: With `bus_type` high, `rd_ds_n` is an active-low data strobe. When the strobe is active, `wr_rw_n` high means a read and `wr_rw_n` low means a write.
- R6: A write commits on the trailing edge of its strobe. `reg_wr_en` is high for exactly one cycle, the cycle after the strobe is first sampled inactive. During that cycle, `reg_addr` and `reg_wdata` carry the address and the last data sampled while the strobe was active.
- R7: Address 0Fh reads `{1'b1, DEV_CODE[2:0], DIE_REV[3:0]}`, which is A3h by default. Writes to 0Fh are ignored.
- R8: Addresses 09h–0Eh and BCh–BFh read 00h. Writes to them are ignored and not forwarded.
- R9: Addresses C0h–FFh read 00h. Writes to them are ignored and not forwarded.
- R10: `ad_oe` is high only in the cycle after a read strobe is sampled active. While `ad_oe` is low, `ad_out` is 00h.
- R11: Every other address, including 15h and 19h, is forwarded. Writes reach the register file, and reads return `reg_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples every host pin |
| rst_n | input | 1 | Active-low asynchronous reset |
| mux_sel | input | 1 | Strap: 1 = shared address/data bus, 0 = split bus |
| bus_type | input | 1 | Strap: 0 = read/write strobes, 1 = data strobe with direction |
| cs_n | input | 1 | Active-low chip select |
| rd_ds_n | input | 1 | Read strobe or data strobe, active low |
| wr_rw_n | input | 1 | Write strobe, or direction line (1 = read) |
| ale_a7 | input | 1 | Address latch enable (shared bus) or address bit 7 (split bus) |
| addr_lo | input | 7 | Address bits 6..0 on the split bus |
| ad_in | input | 8 | Data pins, or address and data pins on the shared bus |
| ad_out | output | 8 | Read data driven to the host |
| ad_oe | output | 1 | Drive enable for the data pins |
| reg_addr | output | 8 | Register address sent to the register file |
| reg_wdata | output | 8 | Write data sent to the register file |
| reg_wr_en | output | 1 | Single-cycle write commit |
| reg_rd_en | output | 1 | Read of a forwarded address in progress |
| reg_rdata | input | 8 | Read data from the register file |

## Verification
A corrupted latched address would show up at once as a wrong `reg_addr` at the write commit. It would also show as read data from the wrong location on the first read after the address phase. A stuck strobe history would show within one cycle of the strobe ending: either a missing commit pulse or a pulse that lasts longer than one cycle. Decode errors for the ID, reserved or inaccessible ranges would show in the next read of those addresses. They would also show as a stray commit at the register file, which the scoreboard records as unexpected.

// File: rtl/e1_host_port.sv
module e1_host_port #(
  parameter logic [2:0] DEV_CODE = 3'b010,
  parameter logic [3:0] DIE_REV  = 4'h3,
  parameter int         AW       = 8,
  parameter int         DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mux_sel,
  input  logic          bus_type,
  input  logic          cs_n,
  input  logic          rd_ds_n,
  input  logic          wr_rw_n,
  input  logic          ale_a7,
  input  logic [AW-2:0] addr_lo,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_wr_en,
  output logic          reg_rd_en,
  input  logic [DW-1:0] reg_rdata
);
  localparam logic [AW-1:0] ID_ADDR = AW'(8'h0F);
  localparam logic [DW-1:0] ID_VAL  = DW'({1'b1, DEV_CODE, DIE_REV});

  logic          ale_q, rd_q, wr_q, wr_en_q;
  logic [AW-1:0] mux_addr_q, acc_addr_q, cur_addr;
  logic [DW-1:0] wdat_q;
  logic          rd_act, wr_act, acc_local;

  function automatic logic local_addr(input logic [AW-1:0] a);
    return (a >= AW'(8'h09) && a <= AW'(8'h0F)) ||
           (a >= AW'(8'hBC) && a <= AW'(8'hBF)) ||
           (a >= AW'(8'hC0));
  endfunction

  assign cur_addr  = mux_sel ? mux_addr_q : {ale_a7, addr_lo};
  assign rd_act    = ~cs_n & (bus_type ? (~rd_ds_n &  wr_rw_n) : ~rd_ds_n);
  assign wr_act    = ~cs_n & (bus_type ? (~rd_ds_n & ~wr_rw_n) : ~wr_rw_n);
  assign acc_local = local_addr(acc_addr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q      <= 1'b0;
      rd_q       <= 1'b0;
      wr_q       <= 1'b0;
      wr_en_q    <= 1'b0;
      mux_addr_q <= '0;
      acc_addr_q <= '0;
      wdat_q     <= '0;
    end else begin
      ale_q   <= ale_a7;
      rd_q    <= rd_act;
      wr_q    <= wr_act;
      wr_en_q <= wr_q & ~wr_act & ~acc_local;
      if (mux_sel && ale_a7 && !ale_q) mux_addr_q <= ad_in[AW-1:0];
      if (rd_act || wr_act)             acc_addr_q <= cur_addr;
      if (wr_act)                       wdat_q     <= ad_in;
    end
  end

  assign reg_addr  = acc_addr_q;
  assign reg_wdata = wdat_q;
  assign reg_wr_en = wr_en_q;
  assign reg_rd_en = rd_q & ~acc_local;
  assign ad_oe     = rd_q;
  assign ad_out    = !rd_q                   ? '0     :
                     (acc_addr_q == ID_ADDR) ? ID_VAL :
                     acc_local               ? '0     : reg_rdata;
endmodule

module e1_host_port_chk #(
  parameter logic [2:0] DEV_CODE = 3'b010,
  parameter logic [3:0] DIE_REV  = 4'h3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       ad_oe,
  input logic [7:0] ad_out,
  input logic [7:0] reg_addr,
  input logic       reg_wr_en,
  input logic       reg_rd_en
);
  AST_WR_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> $past(cs_n, 2) == 1'b0); // R1
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en); // R6
  AST_ID_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && reg_addr == 8'h0F) |-> ad_out == {1'b1, DEV_CODE, DIE_REV}); // R7
  AST_NO_WR_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> !((reg_addr >= 8'h09 && reg_addr <= 8'h0F) ||
                    (reg_addr >= 8'hBC && reg_addr <= 8'hBF))); // R8
  AST_NO_WR_HIGH_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> reg_addr < 8'hC0); // R9
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !ad_oe |-> (ad_out == 8'h00 && !reg_rd_en)); // R10
endmodule

bind e1_host_port e1_host_port_chk #(.DEV_CODE(DEV_CODE), .DIE_REV(DIE_REV)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ad_oe(ad_oe), .ad_out(ad_out),
  .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en)
);

// File: tb/e1_host_port_bench.sv
module e1_host_port_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mux_sel = 1'b0, bus_type = 1'b0, cs_n = 1'b1;
  logic rd_ds_n = 1'b1, wr_rw_n = 1'b1, ale_a7 = 1'b0;
  logic [6:0] addr_lo = '0;
  logic [7:0] ad_in = '0;
  logic [7:0] ad_out, reg_addr, reg_wdata, reg_rdata;
  logic ad_oe, reg_wr_en, reg_rd_en;

  int checks = 0, fails = 0;
  logic [15:0] exp_q[$];
  logic [7:0] regfile[256];
  logic [7:0] shadow[256];

  always #4 clk = ~clk;

  e1_host_port u_e1_host_port (
    .clk(clk), .rst_n(rst_n), .mux_sel(mux_sel), .bus_type(bus_type),
    .cs_n(cs_n), .rd_ds_n(rd_ds_n), .wr_rw_n(wr_rw_n), .ale_a7(ale_a7),
    .addr_lo(addr_lo), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr_en(reg_wr_en),
    .reg_rd_en(reg_rd_en), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = regfile[reg_addr];

  initial for (int i = 0; i < 256; i++) begin
    regfile[i] = 8'(i) ^ 8'h5A;
    shadow[i]  = 8'(i) ^ 8'h5A;
  end

  always @(posedge clk) if (rst_n && reg_wr_en) regfile[reg_addr] <= reg_wdata;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: every commit must match the next expected write
  always @(negedge clk) if (rst_n && reg_wr_en) begin
    if (exp_q.size() == 0) check("R1/R8/R9 unexpected write", {reg_addr, reg_wdata}, 16'hxxxx);
    else check("R6 write commit", {reg_addr, reg_wdata}, exp_q.pop_front());
  end

  function automatic logic is_local(input logic [7:0] a);
    return (a >= 8'h09 && a <= 8'h0F) || (a >= 8'hBC) ;
  endfunction

  task automatic addr_phase(input logic [7:0] a);
    if (mux_sel) begin
      addr_lo = ~a[6:0];
      ad_in = a; ale_a7 = 1'b0;
      @(negedge clk); ale_a7 = 1'b1;
      @(negedge clk); ale_a7 = 1'b0; ad_in = 8'hEE;
    end else begin
      ale_a7 = a[7]; addr_lo = a[6:0];
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input logic sel);
    @(negedge clk); cs_n = ~sel;
    addr_phase(a);
    @(negedge clk); ad_in = d;
    if (bus_type) begin wr_rw_n = 1'b0; @(negedge clk); rd_ds_n = 1'b0; end
    else wr_rw_n = 1'b0;
    if (sel && !is_local(a)) begin exp_q.push_back({a, d}); shadow[a] = d; end
    repeat (2) @(negedge clk);
    if (bus_type) begin rd_ds_n = 1'b1; @(negedge clk); wr_rw_n = 1'b1; end
    else wr_rw_n = 1'b1;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic sel, output logic [7:0] d, output logic oe);
    @(negedge clk); cs_n = ~sel;
    addr_phase(a);
    @(negedge clk);
    if (bus_type) wr_rw_n = 1'b1;
    rd_ds_n = 1'b0;
    repeat (2) @(negedge clk);
    d = ad_out; oe = ad_oe;
    rd_ds_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic oe;
    repeat (3) @(negedge clk);
    check("R10 reset oe", {15'd0, ad_oe}, 16'd0);
    check("R10 reset data", {8'd0, ad_out}, 16'd0);
    check("R6 reset wr_en", {15'd0, reg_wr_en}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int m = 0; m < 4; m++) begin
      logic [7:0] a;
      bus_type = m[1]; mux_sel = m[0];
      a = 8'h20 + 8'(m * 8'h21);
      // R2 R3 R4 R5 R11: write then read back in each mode
      bus_write(a, 8'hC0 + 8'(m), 1'b1);
      bus_read(a, 1'b1, d, oe);
      check("R2/R3/R4/R5 readback", {7'd0, oe, d}, {8'h01, shadow[a]});
      bus_write(8'hA4 + 8'(m), 8'h3C ^ 8'(m), 1'b1);
      bus_read(8'hA4 + 8'(m), 1'b1, d, oe);
      check("R2 bit7 address", {8'd0, d}, {8'd0, shadow[8'hA4 + 8'(m)]});
      bus_read(8'h0F, 1'b1, d, oe);
      check("R7 id read", {8'd0, d}, 16'h00A3);
    end

    bus_type = 1'b0; mux_sel = 1'b0;
    bus_write(8'h15, 8'h00, 1'b1);
    bus_write(8'h19, 8'h00, 1'b1);
    bus_read(8'h15, 1'b1, d, oe);
    check("R11 test reg 15h", {8'd0, d}, 16'h0000);
    bus_read(8'h19, 1'b1, d, oe);
    check("R11 test reg 19h", {8'd0, d}, 16'h0000);

    bus_write(8'h0F, 8'h11, 1'b1);
    bus_read(8'h0F, 1'b1, d, oe);
    check("R7 id after write", {8'd0, d}, 16'h00A3);

    bus_type = 1'b1; mux_sel = 1'b1;
    bus_write(8'h0A, 8'hFF, 1'b1);
    bus_read(8'h0A, 1'b1, d, oe);
    check("R8 reserved 0Ah", {7'd0, oe, d}, 16'h0100);
    bus_write(8'hBD, 8'hFF, 1'b1);
    bus_read(8'hBD, 1'b1, d, oe);
    check("R8 reserved BDh", {8'd0, d}, 16'h0000);
    check("R8 no forward", {8'd0, regfile[8'hBD]}, {8'd0, 8'hBD ^ 8'h5A});
    bus_write(8'hC3, 8'h77, 1'b1);
    bus_read(8'hC3, 1'b1, d, oe);
    check("R9 bank C read", {8'd0, d}, 16'h0000);
    bus_read(8'hF0, 1'b1, d, oe);
    check("R9 bank F read", {8'd0, d}, 16'h0000);
    check("R9 no forward", {8'd0, regfile[8'hC3]}, {8'd0, 8'hC3 ^ 8'h5A});

    bus_type = 1'b0; mux_sel = 1'b0;
    bus_write(8'h30, 8'h99, 1'b0);
    bus_read(8'h30, 1'b0, d, oe);
    check("R1 cs high read oe", {7'd0, oe, d}, 16'h0000);
    bus_read(8'h30, 1'b1, d, oe);
    check("R1 cs high write ignored", {8'd0, d}, {8'd0, 8'h30 ^ 8'h5A});

    repeat (4) @(negedge clk);
    check("R6 all commits seen", 16'(exp_q.size()), 16'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule